// File: doc/BRIEF.md
# Multiplexed three-digit BCD counter

This block counts events in decimal across three cascaded decades: units, tens and hundreds. The event input is synchronized into the system clock domain and watched for high-to-low transitions. Each accepted falling edge advances the units decade by one. When a decade rolls over from nine back to zero, the next decade advances in the same clock cycle. A disable input blocks counting. A synchronous clear input returns the block to zero.

Every decade drives its own four-bit holding register. This lets the displayed value be frozen while the decades keep counting. A single four-bit bus carries the displayed digits one at a time, and a one-hot select vector names the digit on the bus. A scan-tick pulse, supplied from a slow timebase elsewhere on the chip, steps the select to the next digit. A one-cycle wrap pulse marks the count passing from 999 to 000, so a further counter can extend the range.

Top module: `bcd3_scan_counter`

## Requirements
- R1: After a two-flop synchronizer, every high-to-low transition of `cnt_in` adds one to the count. Rising edges and steady levels leave the count unchanged. When the input is held stable for four clocks in each phase, every pulse is counted.
- R2: Each decade holds a value from 0 to 9 and returns to 0 after 9. The next decade advances in the same cycle as that wrap, so 9 goes to 10 and 99 goes to 100.
- R3: While `freeze` is low, the displayed digits follow the live count. While `freeze` is high, the displayed digits keep the value they had when it rose, and counting carries on underneath. When `freeze` falls, the display shows the live count at once.
- R4: While `hold_cnt` is high, falling edges on `cnt_in` do not change the count.
- R5: `clr` high at a clock edge returns the decades, the holding registers and the digit selector to zero, whatever `hold_cnt` and `freeze` are doing. After the clear, `digit_sel` reads 3'b001.
- R6: `digit_sel` always has exactly one bit set. Bit 0 selects the units digit, bit 1 the tens digit and bit 2 the hundreds digit. `digit_bus` carries the displayed BCD value of the selected digit.
- R7: Each clock cycle with `scan_tick` high moves the selection one place in the order units, tens, hundreds, and then back to units. Without a tick the selection does not move.
- R8: `wrap_out` is high for exactly one clock cycle, in the cycle where the count goes from 999 to 000. It is low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Synchronous clear, active high |
| cnt_in | input | 1 | Event input, counted on its falling edge |
| hold_cnt | input | 1 | Counting disable, active high |
| freeze | input | 1 | Display hold, active high |
| scan_tick | input | 1 | One-cycle pulse that steps the digit scan |
| digit_bus | output | 4 | BCD value of the selected digit |
| digit_sel | output | 3 | One-hot digit select, bit 0 = units |
| wrap_out | output | 1 | One-cycle pulse on 999 to 000 |

## Verification
The assertions check these properties on every clock cycle:
- Each decade stays within 0 to 9, and a decade that carries out reads 0 on the next cycle.
- The count does not move while the disable is high, and a clear gives zero.
- The wrap pulse lasts one cycle and coincides with a zero count.
- The select stays one-hot and moves only on a tick.
- A frozen display does not change.

Only the bench scenarios can show the values themselves. These are: the right totals after trains of pulses, the carries at 10 and 100, the frozen value and its release to the live count, the exact scan order with the digit on the bus, and exactly one wrap pulse after a thousand events.

// File: rtl/bcd3_pkg.sv
package bcd3_pkg;
  localparam int DIGIT_W = 4;

  // Next value of one decimal decade.
  function automatic logic [DIGIT_W-1:0] bcd_next(input logic [DIGIT_W-1:0] d);
    return (d >= 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  function automatic logic at_nine(input logic [DIGIT_W-1:0] d);
    return d == 4'd9;
  endfunction

  // Next scan position, wrapping after n positions.
  function automatic int scan_next(input int i, input int n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (clr) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign fall = last & ~chain[STAGES-1];

  // R1: a falling edge is reported one cycle after the synced level was high.
  p_fall_origin_r1: assert property (@(posedge clk) disable iff (clr)
    fall |-> $past(chain[STAGES-1]));
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd3_pkg::*;
(
  input  logic               clk,
  input  logic               clr,
  input  logic               step,
  input  logic               freeze,
  output logic [DIGIT_W-1:0] q_live,
  output logic [DIGIT_W-1:0] q_shown,
  output logic               carry
);
  logic [DIGIT_W-1:0] cnt, cnt_n, held;

  always_comb cnt_n = step ? bcd_next(cnt) : cnt;

  always_ff @(posedge clk) begin
    if (clr) cnt <= '0;
    else     cnt <= cnt_n;
  end

  // The holding register tracks the next count, so it always equals the live count while open.
  always_ff @(posedge clk) begin
    if (clr)          held <= '0;
    else if (!freeze) held <= cnt_n;
  end

  assign q_live  = cnt;
  assign q_shown = freeze ? held : cnt;
  assign carry   = step & at_nine(cnt);

  p_digit_range_r2: assert property (@(posedge clk) disable iff (clr)
    q_live <= 4'd9);
  p_carry_wrap_r2: assert property (@(posedge clk) disable iff (clr)
    carry |=> (q_live == 4'd0));
  p_frozen_stable_r3: assert property (@(posedge clk) disable iff (clr)
    (freeze && $past(freeze) && !$past(clr)) |-> $stable(q_shown));
endmodule

// File: rtl/scan_mux.sv
module scan_mux
  import bcd3_pkg::*;
#(
  parameter int NDIG = 3
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    tick,
  input  logic [NDIG*DIGIT_W-1:0] shown,
  output logic [DIGIT_W-1:0]      bus,
  output logic [NDIG-1:0]         sel
);
  localparam int IW = (NDIG > 1) ? $clog2(NDIG) : 1;

  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (clr)       idx <= '0;
    else if (tick) idx <= IW'(scan_next(int'(idx), NDIG));
  end

  always_comb begin
    sel = '0;
    bus = '0;
    for (int k = 0; k < NDIG; k++) begin
      if (int'(idx) == k) begin
        sel[k] = 1'b1;
        bus    = shown[k*DIGIT_W +: DIGIT_W];
      end
    end
  end

  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (clr)
    $countones(sel) == 1);
  p_sel_still_r7: assert property (@(posedge clk) disable iff (clr)
    !tick |=> $stable(sel));
endmodule

// File: rtl/bcd3_scan_counter.sv
module bcd3_scan_counter
  import bcd3_pkg::*;
#(
  parameter int NDIG        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               cnt_in,
  input  logic               hold_cnt,
  input  logic               freeze,
  input  logic               scan_tick,
  output logic [DIGIT_W-1:0] digit_bus,
  output logic [NDIG-1:0]    digit_sel,
  output logic               wrap_out
);
  localparam int TOT_W = NDIG * DIGIT_W;

  logic                  fall_evt;
  logic                  step;
  logic [NDIG:0]         carry_chain;
  logic [TOT_W-1:0]      live_count;
  logic [TOT_W-1:0]      shown_count;
  logic                  wrap_evt;

  edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .clr  (clr),
    .din  (cnt_in),
    .fall (fall_evt)
  );

  assign step           = fall_evt & ~hold_cnt & ~clr;
  assign carry_chain[0] = step;

  for (genvar g = 0; g < NDIG; g++) begin : g_dec
    bcd_decade u_dec (
      .clk     (clk),
      .clr     (clr),
      .step    (carry_chain[g]),
      .freeze  (freeze),
      .q_live  (live_count[g*DIGIT_W +: DIGIT_W]),
      .q_shown (shown_count[g*DIGIT_W +: DIGIT_W]),
      .carry   (carry_chain[g+1])
    );
  end

  assign wrap_evt = carry_chain[NDIG];

  always_ff @(posedge clk) begin
    if (clr) wrap_out <= 1'b0;
    else     wrap_out <= wrap_evt;
  end

  scan_mux #(.NDIG(NDIG)) u_scan (
    .clk   (clk),
    .clr   (clr),
    .tick  (scan_tick),
    .shown (shown_count),
    .bus   (digit_bus),
    .sel   (digit_sel)
  );

  p_disable_hold_r4: assert property (@(posedge clk) disable iff (clr)
    hold_cnt |=> $stable(live_count));
  p_clear_zero_r5: assert property (@(posedge clk)
    clr |=> (live_count == '0));
  p_wrap_single_r8: assert property (@(posedge clk) disable iff (clr)
    wrap_out |=> !wrap_out);
  p_wrap_at_zero_r8: assert property (@(posedge clk) disable iff (clr)
    wrap_out |-> (live_count == '0));
endmodule

// File: tb/sim_bcd3_scan_counter.sv
module sim_bcd3_scan_counter;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       cnt_in = 1'b0;
  logic       hold_cnt = 1'b0;
  logic       freeze = 1'b0;
  logic       scan_tick = 1'b0;
  logic [3:0] digit_bus;
  logic [2:0] digit_sel;
  logic       wrap_out;

  int    n_run = 0;
  int    n_fail = 0;
  int    wrap_cnt = 0;
  int    wrap_long = 0;
  logic  wrap_d = 1'b0;
  int    exp_q[$];
  string tag_q[$];
  int    obs_val;
  event  obs_ev;

  always #(CLK_P/2) clk = ~clk;

  bcd3_scan_counter u0 (
    .clk(clk), .clr(clr), .cnt_in(cnt_in), .hold_cnt(hold_cnt),
    .freeze(freeze), .scan_tick(scan_tick),
    .digit_bus(digit_bus), .digit_sel(digit_sel), .wrap_out(wrap_out)
  );

  always @(posedge clk) begin
    wrap_d <= wrap_out;
    if (wrap_out) wrap_cnt <= wrap_cnt + 1;
    if (wrap_out && wrap_d) wrap_long <= wrap_long + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops each expected item and compares it with the value just read back.
  always @(obs_ev) begin
    int    e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(t, obs_val, e);
  end

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cnt_in = 1'b1;
      repeat (4) @(negedge clk);
      cnt_in = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  // Scan all three digits starting from the units position; the selector returns to units.
  task automatic read_display(output int val);
    int d[3];
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      d[k] = int'(digit_bus);
      scan_tick = 1'b1;
      @(negedge clk);
      scan_tick = 1'b0;
    end
    val = d[2] * 100 + d[1] * 10 + d[0];
  endtask

  task automatic expect_display(input string tag, input int exp);
    int v;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    read_display(v);
    obs_val = v;
    ->obs_ev;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    chk("R5 select after clear", int'(digit_sel), 1);
    chk("R8 wrap low after clear", int'(wrap_out), 0);
    expect_display("R5 display after clear", 0);

    pulse(7);
    expect_display("R1 seven falling edges", 7);
    @(negedge clk) cnt_in = 1'b1;
    expect_display("R1 rising edge ignored", 7);
    @(negedge clk) cnt_in = 1'b0;
    repeat (4) @(negedge clk);
    expect_display("R1 eighth falling edge", 8);

    pulse(2);
    expect_display("R2 carry into tens", 10);
    pulse(90);
    expect_display("R2 carry into hundreds", 100);

    @(negedge clk) hold_cnt = 1'b1;
    pulse(5);
    @(negedge clk) hold_cnt = 1'b0;
    expect_display("R4 disable blocks counting", 100);

    @(negedge clk) freeze = 1'b1;
    pulse(3);
    expect_display("R3 frozen display", 100);
    @(negedge clk) freeze = 1'b0;
    expect_display("R3 released display", 103);

    // Scan order and bus contents for 103: units 3, tens 0, hundreds 1.
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 scan order", int'(digit_sel), 1 << (k % 3));
      chk("R6 digit on bus", int'(digit_bus), (k % 3 == 0) ? 3 : ((k % 3 == 1) ? 0 : 1));
      scan_tick = 1'b1;
      @(negedge clk) scan_tick = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk("R7 no tick holds select", int'(digit_sel), 2);
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;

    @(negedge clk) begin hold_cnt = 1'b1; freeze = 1'b1; clr = 1'b1; end
    @(negedge clk) begin clr = 1'b0; hold_cnt = 1'b0; freeze = 1'b0; end
    chk("R5 select reset to units", int'(digit_sel), 1);
    expect_display("R5 clear overrides disable", 0);

    pulse(999);
    expect_display("R2 full count", 999);
    chk("R8 no wrap before 1000", wrap_cnt, 0);
    pulse(1);
    expect_display("R8 rolls to zero", 0);
    chk("R8 one wrap pulse", wrap_cnt, 1);
    chk("R8 pulse lasts one cycle", wrap_long, 0);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule